// File: doc/BRIEF.md
# Welch-Berlekamp Key Equation Solver

This block finds the error locator and error evaluator polynomials for a double-error-correcting Reed-Solomon decoder over GF(64). The re-encoder upstream supplies four parity-check symbols, one per transfer. The solver pairs the k-th symbol of a codeword with the location alpha^k. It then runs one interpolation update per pair on four working polynomials: a candidate locator/evaluator pair (Q, N) and an auxiliary pair (W, V).

Each update evaluates two discrepancies from the current polynomials. It then applies one of three rules. The rule is chosen from the first discrepancy and from a small signed counter J. J tracks how far the auxiliary pair leads the candidate pair in degree, so no polynomial degrees are ever compared. After the fourth pair the block pulses a done flag. The final Q and N stay on the outputs for the Chien search stage until the next codeword starts. The field arithmetic (multiply, inverse, Horner evaluation) is built in.

Top module: `wb_key_solver`

## Requirements
- R1: After reset, busy_o and done_o are 0, q_o holds the polynomial 1 (coefficient 0 equal to 1, all others 0) and n_o is all zero.
- R2: A pair is taken on a rising edge where pair_valid_i is 1 and busy_o is 0. busy_o is then 1 for exactly the two following cycles. A pair_valid_i offered while busy_o is 1 is ignored.
- R3: Arithmetic is in GF(64) with field polynomial x^6+x+1 and alpha = 6'b000010. The k-th pair accepted within a codeword (k = 0..3) uses location alpha^k. Polynomial coefficient i sits at bits [6i+5:6i] of q_o and n_o.
- R4: Each step computes D1 = R*Q(L) + N(L) and D2 = R*W(L) + V(L), where addition is XOR. If D1 = 0, W and V are each multiplied by (x + L), Q and N are unchanged, and J increases by 1.
- R5: If D1 is not 0 and J >= 1, W becomes W + Q*D2/D1 and V becomes V + N*D2/D1. Q and N are each multiplied by (x + L), and J decreases by 1.
- R6: If D1 is not 0 and J = 0, W and V become Q*(x + L) and N*(x + L). Q and N become W + Q*D2/D1 and V + N*D2/D1, with all terms taken from the values before the step. J becomes 1.
- R7: The fourth pair of a codeword makes done_o 1 for exactly one cycle, on the cycle when that pair's update appears on q_o/n_o. q_o and n_o then hold until the next accepted pair.
- R8: The first pair of each codeword restarts from Q = 1, N = 0, W = x, V = 1, J = 1, whatever the previous codeword left behind.
- R9: When done_o is 1, the outputs satisfy R_k*Q(alpha^k) + N(alpha^k) = 0 for all four pairs of that codeword.
- R10: A codeword whose four check symbols are all zero ends with q_o equal to 1 and n_o equal to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pair_valid_i | input | 1 | Check symbol offered this cycle |
| pair_r_i | input | 6 | Parity-check symbol R_k |
| busy_o | output | 1 | Step in progress; input is not taken |
| done_o | output | 1 | One-cycle pulse: locator and evaluator are final |
| q_o | output | 36 | Locator polynomial, 6 coefficients of 6 bits |
| n_o | output | 36 | Evaluator polynomial, 6 coefficients of 6 bits |

## Verification
A pair taken on rising edge E raises busy_o right after E. Busy holds through edge E+1, when the discrepancies are registered. The polynomial update appears on q_o and n_o right after edge E+2, and so does done_o for the fourth pair. busy_o falls at that same edge.

The bench steps a behavioural model through the same edges. The model uses log and antilog tables for the field. Every output is compared at each falling edge, so each result is checked in the cycle it is due and in every cycle it must hold. Junk pairs offered during the two busy cycles, codewords sent back to back, and the all-zero codeword cover the ignore, restart and trivial cases.

// File: rtl/wb_gf_pkg.sv
package wb_gf_pkg;
  localparam int SYM_W = 6;
  localparam logic [SYM_W:0] PRIM = 7'b1000011;  // x^6 + x + 1

  typedef logic [SYM_W-1:0] sym_t;
  typedef enum logic [1:0] {ST_IDLE, ST_EVAL, ST_UPD} st_e;

  function automatic sym_t gf_mul(input sym_t a, input sym_t b);
    sym_t acc;
    sym_t sh;
    acc = '0;
    sh  = a;
    for (int i = 0; i < SYM_W; i++) begin
      if (b[i]) acc = acc ^ sh;
      if (sh[SYM_W-1]) sh = (sh << 1) ^ PRIM[SYM_W-1:0];
      else             sh = sh << 1;
    end
    return acc;
  endfunction
endpackage

// File: rtl/gf_mul_unit.sv
module gf_mul_unit
  import wb_gf_pkg::*;
(
  input  sym_t a_i,
  input  sym_t b_i,
  output sym_t p_o
);
  assign p_o = gf_mul(a_i, b_i);
endmodule

// File: rtl/gf_inv_unit.sv
module gf_inv_unit
  import wb_gf_pkg::*;
(
  input  sym_t a_i,
  output sym_t inv_o
);
  sym_t inv_c;

  // a^(2^m - 2): product of a^2, a^4, ..., a^(2^(m-1))
  always_comb begin
    sym_t pw;
    pw    = a_i;
    inv_c = sym_t'(1);
    for (int i = 1; i < SYM_W; i++) begin
      pw    = gf_mul(pw, pw);
      inv_c = gf_mul(inv_c, pw);
    end
    if (a_i != '0) begin
      a_r5_inverse_ok: assert (gf_mul(a_i, inv_c) == sym_t'(1));
    end
  end

  assign inv_o = inv_c;
endmodule

// File: rtl/poly_eval.sv
module poly_eval
  import wb_gf_pkg::*;
#(
  parameter int NCOEF = 6
) (
  input  logic [NCOEF-1:0][SYM_W-1:0] coef_i,
  input  sym_t                        x_i,
  output sym_t                        val_o
);
  logic [NCOEF-1:0][SYM_W-1:0] acc;
  logic [NCOEF-1:0][SYM_W-1:0] prod;

  assign acc[NCOEF-1]  = coef_i[NCOEF-1];
  assign prod[NCOEF-1] = '0;

  // Horner chain, top coefficient first
  for (genvar i = NCOEF - 2; i >= 0; i--) begin : g_horner
    gf_mul_unit u_mul (.a_i(acc[i+1]), .b_i(x_i), .p_o(prod[i]));
    assign acc[i] = prod[i] ^ coef_i[i];
  end

  assign val_o = acc[0];
endmodule

// File: rtl/wb_key_solver.sv
module wb_key_solver
  import wb_gf_pkg::*;
#(
  parameter int NCOEF  = 6,
  parameter int NPAIRS = 4,
  parameter int JW     = 4
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   pair_valid_i,
  input  logic [SYM_W-1:0]       pair_r_i,
  output logic                   busy_o,
  output logic                   done_o,
  output logic [NCOEF*SYM_W-1:0] q_o,
  output logic [NCOEF*SYM_W-1:0] n_o
);
  localparam int CNT_W = $clog2(NPAIRS + 1);
  localparam logic [NCOEF-1:0][SYM_W-1:0] POLY_ONE =
    {{((NCOEF-1)*SYM_W){1'b0}}, SYM_W'(1)};
  localparam logic [NCOEF-1:0][SYM_W-1:0] POLY_X =
    {{((NCOEF-2)*SYM_W){1'b0}}, SYM_W'(1), SYM_W'(0)};
  localparam sym_t ALPHA = SYM_W'(2);

  typedef logic [NCOEF-1:0][SYM_W-1:0] poly_t;

  st_e                st_q;
  poly_t              q_q, n_q, w_q, v_q;
  logic signed [JW-1:0] j_q;
  logic [CNT_W-1:0]   cnt_q;
  sym_t               loc_q, r_q, d1_q, d2_q;
  logic               done_q;

  sym_t  q_at, n_at, w_at, v_at;
  sym_t  d1_c, d2_c, d1_inv, ratio;
  poly_t qr_v, nr_v, ql_v, nl_v, wl_v, vl_v;
  poly_t qx_v, nx_v, wx_v, vx_v;
  logic  accept, j_pos;

  poly_eval #(.NCOEF(NCOEF)) u_ev_q (.coef_i(q_q), .x_i(loc_q), .val_o(q_at));
  poly_eval #(.NCOEF(NCOEF)) u_ev_n (.coef_i(n_q), .x_i(loc_q), .val_o(n_at));
  poly_eval #(.NCOEF(NCOEF)) u_ev_w (.coef_i(w_q), .x_i(loc_q), .val_o(w_at));
  poly_eval #(.NCOEF(NCOEF)) u_ev_v (.coef_i(v_q), .x_i(loc_q), .val_o(v_at));

  assign d1_c = gf_mul(r_q, q_at) ^ n_at;
  assign d2_c = gf_mul(r_q, w_at) ^ v_at;

  gf_inv_unit u_inv (.a_i(d1_q), .inv_o(d1_inv));
  gf_mul_unit u_ratio (.a_i(d2_q), .b_i(d1_inv), .p_o(ratio));

  // Per-coefficient scaled terms and (x + L) products
  for (genvar i = 0; i < NCOEF; i++) begin : g_coef
    gf_mul_unit u_qr (.a_i(q_q[i]), .b_i(ratio), .p_o(qr_v[i]));
    gf_mul_unit u_nr (.a_i(n_q[i]), .b_i(ratio), .p_o(nr_v[i]));
    gf_mul_unit u_ql (.a_i(q_q[i]), .b_i(loc_q), .p_o(ql_v[i]));
    gf_mul_unit u_nl (.a_i(n_q[i]), .b_i(loc_q), .p_o(nl_v[i]));
    gf_mul_unit u_wl (.a_i(w_q[i]), .b_i(loc_q), .p_o(wl_v[i]));
    gf_mul_unit u_vl (.a_i(v_q[i]), .b_i(loc_q), .p_o(vl_v[i]));
    if (i == 0) begin : g_lo
      assign qx_v[i] = ql_v[i];
      assign nx_v[i] = nl_v[i];
      assign wx_v[i] = wl_v[i];
      assign vx_v[i] = vl_v[i];
    end else begin : g_hi
      assign qx_v[i] = ql_v[i] ^ q_q[i-1];
      assign nx_v[i] = nl_v[i] ^ n_q[i-1];
      assign wx_v[i] = wl_v[i] ^ w_q[i-1];
      assign vx_v[i] = vl_v[i] ^ v_q[i-1];
    end
  end

  assign accept = (st_q == ST_IDLE) && pair_valid_i;
  assign j_pos  = !j_q[JW-1] && (j_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      q_q    <= POLY_ONE;
      n_q    <= '0;
      w_q    <= POLY_X;
      v_q    <= POLY_ONE;
      j_q    <= JW'(1);
      cnt_q  <= '0;
      loc_q  <= SYM_W'(1);
      r_q    <= '0;
      d1_q   <= '0;
      d2_q   <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          if (accept) begin
            r_q  <= pair_r_i;
            st_q <= ST_EVAL;
            if (cnt_q == '0) begin
              q_q   <= POLY_ONE;
              n_q   <= '0;
              w_q   <= POLY_X;
              v_q   <= POLY_ONE;
              j_q   <= JW'(1);
              loc_q <= SYM_W'(1);
            end
          end
        end
        ST_EVAL: begin
          d1_q <= d1_c;
          d2_q <= d2_c;
          st_q <= ST_UPD;
        end
        ST_UPD: begin
          if (d1_q == '0) begin
            w_q <= wx_v;
            v_q <= vx_v;
            j_q <= j_q + JW'(1);
          end else if (j_pos) begin
            w_q <= w_q ^ qr_v;
            v_q <= v_q ^ nr_v;
            q_q <= qx_v;
            n_q <= nx_v;
            j_q <= j_q - JW'(1);
          end else begin
            w_q <= qx_v;
            v_q <= nx_v;
            q_q <= w_q ^ qr_v;
            n_q <= v_q ^ nr_v;
            j_q <= JW'(1);
          end
          loc_q <= gf_mul(loc_q, ALPHA);
          if (cnt_q == CNT_W'(NPAIRS - 1)) begin
            cnt_q  <= '0;
            done_q <= 1'b1;
          end else begin
            cnt_q <= cnt_q + CNT_W'(1);
          end
          st_q <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o = (st_q != ST_IDLE);
  assign done_o = done_q;
  assign q_o    = q_q;
  assign n_o    = n_q;

  a_r2_accept_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pair_valid_i && !busy_o) |=> busy_o);
  a_r2_busy_two: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |=> busy_o);
  a_r2_busy_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_UPD) |=> !busy_o);
  a_r4_branch_a_keeps_q: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_UPD && d1_q == '0) |=> ($stable(q_o) && $stable(n_o)));
  a_r6_branch_b_j: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_UPD && d1_q != '0 && j_q == '0) |=> (j_q == JW'(1)));
  a_r7_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r7_hold_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !pair_valid_i) |=> ($stable(q_o) && $stable(n_o)));
  a_r5_j_nonneg: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_UPD) |=> !j_q[JW-1]);
endmodule

// File: tb/wb_key_solver_tb_top.sv
module wb_key_solver_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NC = 6;
  localparam int PW = NC * 6;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          pair_valid_i = 1'b0;
  logic [5:0]    pair_r_i = '0;
  logic          busy_o, done_o;
  logic [PW-1:0] q_o, n_o;

  wb_key_solver dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .pair_valid_i(pair_valid_i), .pair_r_i(pair_r_i),
    .busy_o(busy_o), .done_o(done_o), .q_o(q_o), .n_o(n_o)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  int total = 0;
  int bad = 0;
  int gexp[64];
  int glog[64];
  int mq[NC], mn[NC], mw[NC], mv[NC];
  int mj, mcnt, mphase, mr, n_a, n_b, n_c;
  int mrs[4];
  int crs[4];
  logic mdone;
  logic checking = 1'b0;
  logic finished = 1'b0;
  int seed = 32'h1234abcd;

  function automatic int gmul(input int a, input int b);
    if (a == 0 || b == 0) return 0;
    return gexp[(glog[a] + glog[b]) % 63];
  endfunction

  function automatic int ginv(input int a);
    return gexp[(63 - glog[a]) % 63];
  endfunction

  function automatic int peval(input int p[NC], input int x);
    int s = 0;
    int xp = 1;
    for (int i = 0; i < NC; i++) begin
      s ^= gmul(p[i], xp);
      xp = gmul(xp, x);
    end
    return s;
  endfunction

  function automatic logic [PW-1:0] pack(input int p[NC]);
    logic [PW-1:0] v = '0;
    for (int i = 0; i < NC; i++) v[i*6 +: 6] = p[i][5:0];
    return v;
  endfunction

  task automatic mul_lin(input int p[NC], input int l, output int o[NC]);
    for (int i = 0; i < NC; i++) o[i] = gmul(p[i], l) ^ ((i > 0) ? p[i-1] : 0);
  endtask

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_init();
    for (int i = 0; i < NC; i++) begin
      mq[i] = 0; mn[i] = 0; mw[i] = 0; mv[i] = 0;
    end
    mq[0] = 1; mw[1] = 1; mv[0] = 1; mj = 1;
  endtask

  task automatic model_step();
    int l, d1, d2, rt;
    int tq[NC], tn[NC], tw[NC], tv[NC], qs[NC], ns[NC];
    l  = gexp[mcnt];
    d1 = gmul(mr, peval(mq, l)) ^ peval(mn, l);
    d2 = gmul(mr, peval(mw, l)) ^ peval(mv, l);
    if (d1 == 0) begin
      mul_lin(mw, l, tw); mul_lin(mv, l, tv);
      mw = tw; mv = tv; mj++; n_a++;
    end else begin
      rt = gmul(d2, ginv(d1));
      for (int i = 0; i < NC; i++) begin
        qs[i] = mw[i] ^ gmul(mq[i], rt);
        ns[i] = mv[i] ^ gmul(mn[i], rt);
      end
      mul_lin(mq, l, tq); mul_lin(mn, l, tn);
      if (mj >= 1) begin
        mw = qs; mv = ns; mq = tq; mn = tn; mj--; n_c++;
      end else begin
        mw = tq; mv = tn; mq = qs; mn = ns; mj = 1; n_b++;
      end
    end
  endtask

  initial begin
    int e = 1;
    for (int i = 0; i < 63; i++) begin
      gexp[i] = e; glog[e] = i;
      e = e << 1;
      if ((e & 64) != 0) e = e ^ 67;
    end
    gexp[63] = 1; glog[0] = 0;
  end

  // Behavioural reference, stepped on the same rising edges
  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      model_init();
      mcnt = 0; mphase = 0; mdone = 1'b0; mr = 0;
    end else begin
      mdone = 1'b0;
      if (mphase == 0) begin
        if (pair_valid_i) begin
          if (mcnt == 0) model_init();
          mr = int'(pair_r_i); mrs[mcnt] = mr; mphase = 1;
        end
      end else if (mphase == 1) begin
        mphase = 2;
      end else begin
        model_step();
        mcnt++;
        if (mcnt == 4) begin
          mcnt = 0; mdone = 1'b1; crs = mrs;
        end
        mphase = 0;
      end
    end
  end

  always @(negedge clk_i) begin
    if (checking && !finished) begin
      chk("R2 busy", 64'(busy_o), 64'(mphase != 0));
      chk("R7 done", 64'(done_o), 64'(mdone));
      chk("R3 R4 R5 R6 R8 q", 64'(q_o), 64'(pack(mq)));
      chk("R3 R4 R5 R6 R8 n", 64'(n_o), 64'(pack(mn)));
      if (mdone) begin
        int pq[NC], pn[NC];
        for (int i = 0; i < NC; i++) begin
          pq[i] = int'(q_o[i*6 +: 6]);
          pn[i] = int'(n_o[i*6 +: 6]);
        end
        for (int k = 0; k < 4; k++)
          chk("R9 interp", 64'(gmul(crs[k], peval(pq, gexp[k])) ^ peval(pn, gexp[k])), 64'd0);
      end
    end
  end

  task automatic send_pair(input logic [5:0] r, input bit junk);
    while (busy_o) @(negedge clk_i);
    pair_valid_i = 1'b1; pair_r_i = r;
    @(negedge clk_i);
    if (junk) begin
      pair_r_i = ~r;
      @(negedge clk_i);
    end
    pair_valid_i = 1'b0; pair_r_i = '0;
  endtask

  task automatic send_word(input logic [5:0] r0, input logic [5:0] r1,
                           input logic [5:0] r2, input logic [5:0] r3, input bit junk);
    send_pair(r0, junk); send_pair(r1, junk); send_pair(r2, junk); send_pair(r3, junk);
    while (busy_o) @(negedge clk_i);
  endtask

  function automatic logic [5:0] rnd6();
    seed = seed * 1103515245 + 12345;
    return seed[21:16];
  endfunction

  initial begin
    n_a = 0; n_b = 0; n_c = 0;
    repeat (3) @(negedge clk_i);
    chk("R1 busy", 64'(busy_o), 64'd0);
    chk("R1 done", 64'(done_o), 64'd0);
    chk("R1 q", 64'(q_o), 64'd1);
    chk("R1 n", 64'(n_o), 64'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 q after release", 64'(q_o), 64'd1);
    checking = 1'b1;

    send_word(6'd0, 6'd0, 6'd0, 6'd0, 1'b0);
    @(negedge clk_i);
    chk("R10 q", 64'(q_o), 64'd1);
    chk("R10 n", 64'(n_o), 64'd0);

    send_word(6'd1, 6'd1, 6'd1, 6'd1, 1'b0);
    send_word(6'd5, 6'd0, 6'd0, 6'd0, 1'b1);
    send_word(6'd0, 6'd7, 6'd33, 6'd2, 1'b0);
    send_word(6'd63, 6'd62, 6'd1, 6'd40, 1'b1);
    for (int w = 0; w < 60; w++) begin
      send_word(rnd6(), rnd6(), rnd6(), rnd6(), (w % 3) == 0);
      repeat (w % 4) @(negedge clk_i);
    end
    send_word(6'd0, 6'd0, 6'd0, 6'd0, 1'b1);
    @(negedge clk_i);
    chk("R10 q after dirty word (R8)", 64'(q_o), 64'd1);
    chk("R10 n after dirty word (R8)", 64'(n_o), 64'd0);

    chk("R4 branch A seen", 64'(n_a > 0), 64'd1);
    chk("R5 branch C seen", 64'(n_c > 0), 64'd1);
    chk("R6 branch B seen", 64'(n_b > 0), 64'd1);
    repeat (3) @(negedge clk_i);
    if (!finished) begin
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      finished = 1'b1;
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule